// File: doc/BRIEF.md
# Segment Jump Correction Unit

This block straightens the transfer curve of a redundant pipelined converter during normal conversion. The three most significant stages each give a ternary decision. When a stage's gain is slightly low, its sub-range boundaries show up as upward steps in the raw output. Each raw output word arrives together with those three decisions. The block sums the stored step height of each stage, weighted by that stage's decision (-1, 0 or +1). It subtracts the sum from the raw word. The result is that every segment of the curve is moved onto the central segment, which is the one where all three decisions are zero.

The step heights are measured elsewhere and held steady on the coefficient inputs. Only additions and subtractions are used, so there is no multiplier or divider. The corrected word is two bits wider than the raw word. It is clamped at both ends, because the shift can carry codes past either rail. One register stage separates input from output. A decision code that is not legal counts as zero, and the block flags it alongside the sample.

Top module: `seg_jump_corr`

## Requirements
- R1: Each stage decision is a 2-bit code: 2'b10 means +1, 2'b01 means 0, 2'b00 means -1. The code 2'b11 is illegal: it contributes nothing to the correction and sets `out_bad_code` for that sample.
- R2: When all three decisions are 0 (the reference segment), `out_word` equals `in_raw` zero-extended.
- R3: A +1 decision on a stage subtracts that stage's coefficient from the result. A -1 decision adds it. The decision for stage k (k = 1..3) sits in `in_dig[2k-1:2k-2]`. Its coefficient sits in `in_coef[11k-1:11k-11]`.
- R4: The contributions of several stages add together. For example, stages 2 and 3 both at -1 add the sum of their two coefficients, and all stages at +1 subtract the sum of all three.
- R5: A result below zero gives `out_word` = 0.
- R6: A result above 4095 gives `out_word` = 4095, the largest 12-bit code.
- R7: `out_valid` is `in_valid` delayed by exactly one clock. On a cycle with `in_valid` low, `out_word` and `out_bad_code` keep their previous values.
- R8: While `rst_n` is low, `out_valid`, `out_word` and `out_bad_code` are all 0.
- R9: `out_bad_code` is refreshed on every valid sample. It goes low again one cycle after a valid sample that has only legal codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_raw | input | 10 | Raw converter word, unsigned |
| in_dig | input | 6 | Three 2-bit stage decisions, stage 1 in the low bits |
| in_coef | input | 33 | Three 11-bit unsigned step heights, stage 1 in the low bits |
| out_valid | output | 1 | Corrected sample strobe |
| out_word | output | 12 | Corrected, clamped word |
| out_bad_code | output | 1 | Sample carried an illegal decision code |

## Verification
The illegal-code handling and the output clamp can act on the same sample. The bench provokes this by sending an illegal code on one stage while the legal decisions of the other stages drive the sum past a rail. It does this in both directions. It checks three things on that sample: the illegal stage contributes zero, the clamp applies to what the legal stages produce, and the flag is raised. The bench also checks that the next clean sample drops the flag without disturbing the clamped value.

// File: rtl/sjc_pkg.sv
package sjc_pkg;

    typedef enum logic [1:0] {
        DIG_NEG  = 2'b00,
        DIG_ZERO = 2'b01,
        DIG_POS  = 2'b10,
        DIG_BAD  = 2'b11
    } dig_code_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10
    } term_op_e;

    // A +1 decision means the sample sits above the step, so its height is
    // removed; a -1 decision means below, so the height is added back.
    function automatic term_op_e op_of(input logic [1:0] code);
        case (code)
            DIG_POS:  return OP_SUB;
            DIG_NEG:  return OP_ADD;
            default:  return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sjc_digit_dec.sv
module sjc_digit_dec
    import sjc_pkg::*;
(
    input  logic [1:0] code,
    output term_op_e   op,
    output logic       bad
);
    always_comb begin
        op  = op_of(code);
        bad = (code == DIG_BAD);
    end
endmodule

// File: rtl/sjc_term.sv
module sjc_term
    import sjc_pkg::*;
#(
    parameter int COEF_W = 11,
    parameter int SUM_W  = 15
) (
    input  term_op_e                  op,
    input  logic [COEF_W-1:0]         coef,
    output logic signed [SUM_W-1:0]   term
);
    localparam int PAD_W = SUM_W - COEF_W;

    logic signed [SUM_W-1:0] mag;

    always_comb begin
        mag = $signed({{PAD_W{1'b0}}, coef});
        case (op)
            OP_ADD:  term = mag;
            OP_SUB:  term = -mag;
            default: term = '0;
        endcase
    end
endmodule

// File: rtl/sjc_sat.sv
module sjc_sat #(
    parameter int SUM_W = 15,
    parameter int OUT_W = 12
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [OUT_W-1:0]        word
);
    localparam int PAD_W = SUM_W - OUT_W;
    localparam logic signed [SUM_W-1:0] TOP = $signed({{PAD_W{1'b0}}, {OUT_W{1'b1}}});

    always_comb begin
        if (sum < 0) begin
            word = '0;
        end else if (sum > TOP) begin
            word = '1;
        end else begin
            word = sum[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/seg_jump_corr.sv
module seg_jump_corr
    import sjc_pkg::*;
#(
    parameter int RAW_W   = 10,
    parameter int COEF_W  = 11,
    parameter int NUM_STG = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [RAW_W-1:0]            in_raw,
    input  logic [2*NUM_STG-1:0]        in_dig,
    input  logic [NUM_STG*COEF_W-1:0]   in_coef,
    output logic                        out_valid,
    output logic [RAW_W+1:0]            out_word,
    output logic                        out_bad_code
);
    localparam int OUT_W = RAW_W + 2;
    localparam int WIDE  = (RAW_W > COEF_W) ? RAW_W : COEF_W;
    localparam int SUM_W = WIDE + $clog2(NUM_STG + 1) + 2;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [OUT_W-1:0] word;
    } state_t;

    term_op_e                op_v   [NUM_STG];
    logic signed [SUM_W-1:0] term_v [NUM_STG];
    logic [NUM_STG-1:0]      bad_v;
    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        sat_word;
    state_t                  st_d, st_q;

    for (genvar k = 0; k < NUM_STG; k++) begin : g_stage
        sjc_digit_dec u_dec (
            .code (in_dig[2*k +: 2]),
            .op   (op_v[k]),
            .bad  (bad_v[k])
        );
        sjc_term #(.COEF_W(COEF_W), .SUM_W(SUM_W)) u_term (
            .op   (op_v[k]),
            .coef (in_coef[k*COEF_W +: COEF_W]),
            .term (term_v[k])
        );
    end

    always_comb begin
        sum = $signed({{(SUM_W-RAW_W){1'b0}}, in_raw});
        for (int k = 0; k < NUM_STG; k++) begin
            sum = sum + term_v[k];
        end
    end

    sjc_sat #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_sat (
        .sum  (sum),
        .word (sat_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.word = sat_word;
            st_d.bad  = |bad_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign out_word     = st_q.word;
    assign out_bad_code = st_q.bad;

endmodule

// File: rtl/seg_jump_corr_chk.sv
module seg_jump_corr_chk #(
    parameter int RAW_W   = 10,
    parameter int NUM_STG = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [RAW_W-1:0]     in_raw,
    input logic [2*NUM_STG-1:0] in_dig,
    input logic                 out_valid,
    input logic [RAW_W+1:0]     out_word,
    input logic                 out_bad_code
);
    logic any_bad, all_ref;

    always_comb begin
        any_bad = 1'b0;
        all_ref = 1'b1;
        for (int k = 0; k < NUM_STG; k++) begin
            if (in_dig[2*k +: 2] == 2'b11) any_bad = 1'b1;
            if (in_dig[2*k +: 2] != 2'b01) all_ref = 1'b0;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && $stable(out_bad_code))); // R7
    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_bad) |=> out_bad_code); // R1
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_bad) |=> !out_bad_code); // R9
    AST_REF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_ref) |=> (out_word == {2'b00, $past(in_raw)})); // R2

endmodule

bind seg_jump_corr seg_jump_corr_chk #(.RAW_W(RAW_W), .NUM_STG(NUM_STG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_raw       (in_raw),
    .in_dig       (in_dig),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .out_bad_code (out_bad_code)
);

// File: tb/seg_jump_corr_tb.sv
module seg_jump_corr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_raw = '0;
    logic [5:0]  in_dig = 6'b010101;
    logic [32:0] in_coef = '0;
    logic        out_valid;
    logic [11:0] out_word;
    logic        out_bad_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_tag = "R8";
    string exp_tag = "R8";

    int exp_word = 0;
    bit exp_valid = 1'b0;
    bit exp_bad = 1'b0;

    always #10 clk = ~clk;

    seg_jump_corr u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
        .in_dig(in_dig), .in_coef(in_coef), .out_valid(out_valid),
        .out_word(out_word), .out_bad_code(out_bad_code)
    );

    function automatic int dval(input logic [1:0] c);
        case (c)
            2'b10:   return 1;
            2'b00:   return -1;
            default: return 0;
        endcase
    endfunction

    // Behavioural reference: value, clamp, flag, one-cycle delay.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid = 1'b0;
            exp_word  = 0;
            exp_bad   = 1'b0;
        end else begin
            exp_valid = in_valid;
            if (in_valid) begin
                int v;
                v = int'(in_raw);
                for (int k = 0; k < 3; k++) begin
                    v = v - dval(in_dig[2*k +: 2]) * int'(in_coef[11*k +: 11]);
                end
                if (v < 0) v = 0;
                if (v > 4095) v = 4095;
                exp_word = v;
                exp_bad  = (in_dig[1:0] == 2'b11) || (in_dig[3:2] == 2'b11) ||
                           (in_dig[5:4] == 2'b11);
                exp_tag  = cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (out_valid !== exp_valid || int'(out_word) != exp_word ||
                out_bad_code !== exp_bad) begin
                n_fail++;
                $display("FAIL %s per-cycle: got v=%0b w=%0d e=%0b, want v=%0b w=%0d e=%0b",
                         exp_tag, out_valid, out_word, out_bad_code,
                         exp_valid, exp_word, exp_bad);
            end
        end
    end

    task automatic check_lit(input string tag, input int w, input bit e);
        n_checks++;
        if (out_valid !== 1'b1 || int'(out_word) != w || out_bad_code !== e) begin
            n_fail++;
            $display("FAIL %s: got v=%0b w=%0d e=%0b, want v=1 w=%0d e=%0b",
                     tag, out_valid, out_word, out_bad_code, w, e);
        end
    endtask

    // Digits passed as stage1, stage2, stage3.
    task automatic step(input string tag, input int raw,
                        input logic [1:0] d1, input logic [1:0] d2, input logic [1:0] d3,
                        input int s1, input int s2, input int s3, input bit v);
        cur_tag  = tag;
        in_valid = v;
        in_raw   = raw[9:0];
        in_dig   = {d3, d2, d1};
        in_coef  = {s3[10:0], s2[10:0], s1[10:0]};
        @(negedge clk);
    endtask

    localparam logic [1:0] P = 2'b10, Z = 2'b01, N = 2'b00, X = 2'b11;

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_word !== 12'd0 || out_bad_code !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset: got v=%0b w=%0d e=%0b, want 0 0 0",
                     out_valid, out_word, out_bad_code);
        end
        rst_n = 1'b1;
        @(negedge clk);

        step("R2", 500, Z, Z, Z, 100, 50, 25, 1); check_lit("R2", 500, 0);
        step("R3", 500, Z, Z, N, 100, 50, 25, 1); check_lit("R3", 525, 0);
        step("R3", 500, Z, Z, P, 100, 50, 25, 1); check_lit("R3", 475, 0);
        step("R3", 500, P, Z, Z, 100, 50, 25, 1); check_lit("R3", 400, 0);
        step("R4", 500, Z, N, N, 100, 50, 25, 1); check_lit("R4", 575, 0);
        step("R4", 500, P, P, P, 100, 50, 25, 1); check_lit("R4", 325, 0);
        step("R4", 500, N, P, N, 100, 50, 25, 1); check_lit("R4", 575, 0);
        step("R5", 10, P, Z, Z, 100, 50, 25, 1);  check_lit("R5", 0, 0);
        step("R6", 1023, N, N, N, 2047, 2047, 2047, 1); check_lit("R6", 4095, 0);
        step("R1", 500, Z, X, N, 100, 50, 25, 1); check_lit("R1", 525, 1);
        step("R9", 500, Z, Z, Z, 100, 50, 25, 1); check_lit("R9", 500, 0);
        // illegal code and high clamp together, then clean sample
        step("R1", 1000, N, X, N, 2000, 2000, 2000, 1); check_lit("R1", 4095, 1);
        step("R6", 1000, N, N, N, 2000, 2000, 2000, 1); check_lit("R6", 4095, 0);
        // illegal code and low clamp together
        step("R5", 5, X, P, X, 2000, 30, 2000, 1); check_lit("R5", 0, 1);
        // idle cycles with changing inputs must not move the outputs
        step("R7", 77, P, P, P, 1, 1, 1, 0);
        step("R7", 900, X, X, X, 9, 9, 9, 0);
        n_checks++;
        if (out_valid !== 1'b0 || out_word !== 12'd0 || out_bad_code !== 1'b1) begin
            n_fail++;
            $display("FAIL R7 hold: got v=%0b w=%0d e=%0b, want v=0 w=0 e=1",
                     out_valid, out_word, out_bad_code);
        end
        for (int i = 0; i < 600; i++) begin
            logic [1:0] r1, r2, r3;
            r1 = 2'($urandom_range(0, 3));
            r2 = 2'($urandom_range(0, 3));
            r3 = 2'($urandom_range(0, 3));
            step("R4", int'($urandom_range(0, 1023)), r1, r2, r3,
                 int'($urandom_range(0, 2047)), int'($urandom_range(0, 600)),
                 int'($urandom_range(0, 300)), bit'($urandom_range(0, 3) != 0));
        end
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule